// File: doc/BRIEF.md
# Binary-Coded Transient Locator

This block supervises a bank of logic lines that should sit high at all times, such as the outputs of analog comparators under long-term radiation exposure, and reports any brief drop to low. Rather than giving every line its own detector, it groups the lines into a small number of channels. Each channel is the AND of the lines whose index has one particular bit set. A low spike on one line therefore shows up at the same moment on exactly the channels that match the set bits of its index. N channels cover 2^N−1 lines.

Each channel has a falling-edge detector and a run-length counter. A small state machine with the states IDLE, GATHER and MEASURE groups channel pulses whose starts lie close together into one event. The set of channels that took part forms the binary index of the line that glitched. When every channel is back high, the block reports that index together with the longest low run seen among the merged channels. The transitions are: IDLE to GATHER on the first channel fall, GATHER to MEASURE when the coincidence window expires, and MEASURE to IDLE when all channels read high, which also emits the event. The parameters are the channel count, the window length and the width of the run counter.

Top module: `glitch_locator`

## Requirements
- R1: Input line j (1 ≤ j ≤ 2^CH_N−1) is bit j−1 of `lines_i`. Channel k is the AND of every line j whose bit k is one, so a lone low pulse on line j reports index j.
- R2: While reset is active and after it is released, `evt_valid_o`, `evt_index_o`, `evt_width_o` and `evt_err_o` are all zero until the first event.
- R3: A single low pulse on one line that is sampled low on L consecutive clock edges gives one event with index j and width L.
- R4: A channel whose first low sample comes at most WIN_CYC edges after the first low sample of the event is merged, and its bit is set in the index. A channel that starts later is not merged, even when the window is missed by a single edge.
- R5: The reported width is the longest low run, counted in sampled edges, among the merged channels only.
- R6: The width saturates at 2^WID_W−1 for longer runs.
- R7: Let f be the edge at which the first low level of the event is sampled, and h the first later edge at which all lines are sampled high. `evt_valid_o` is high for the cycle that follows edge max(f+WIN_CYC+2, h+1).
- R8: A channel fall that begins after the window has closed and before all channels are back high produces no event of its own, and it does not change the index.
- R9: `evt_err_o` is set with an event exactly when the resolved index is zero. A valid pulse always has a nonzero index, so the flag stays low.
- R10: `evt_valid_o` is a one-cycle pulse. Index, width and error hold their values until the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 2^CH_N−1 | Supervised lines, nominally high; bit j−1 is line j |
| evt_valid_o | output | 1 | One-cycle event strobe |
| evt_index_o | output | CH_N | Resolved line index |
| evt_width_o | output | WID_W | Longest merged low run, in clock cycles |
| evt_err_o | output | 1 | Resolved index was zero |

## Verification
Two of this block's functions can land on the same clock edge. The first is the closing of the coincidence window. The second is either a late channel fall or the end of the last low run. The bench puts a second line's fall exactly WIN_CYC cycles after the first, where it must still be merged, and one cycle later, where it must be dropped without producing an event of its own. It also drives pulses both shorter and longer than the window, so that the report is set by the window in some cases and by the pulse end in others. A behavioural model computes the expected channel runs and the expected report cycle from each line's start and length, and the valid strobe is compared on every clock.

// File: rtl/gl_pkg.sv
package gl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GATHER  = 2'd1,
        ST_MEASURE = 2'd2
    } gl_state_e;

    function automatic int unsigned gl_lines(input int unsigned ch_n);
        return (1 << ch_n) - 1;
    endfunction

endpackage

// File: rtl/gl_fanin.sv
module gl_fanin #(
    parameter int unsigned CH_N  = 3,
    localparam int unsigned LINES = (1 << CH_N) - 1
) (
    input  logic [LINES-1:0] lines_i,
    output logic [CH_N-1:0]  chan_o
);

    for (genvar k = 0; k < CH_N; k++) begin : g_ch
        logic [LINES-1:0] pick;
        for (genvar j = 1; j <= LINES; j++) begin : g_ln
            if (((j >> k) & 1) != 0) begin : g_on
                assign pick[j-1] = lines_i[j-1];
            end else begin : g_off
                assign pick[j-1] = 1'b1;
            end
        end
        assign chan_o[k] = &pick;
    end

endmodule

// File: rtl/gl_chan_det.sv
module gl_chan_det #(
    parameter int unsigned WID_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             chan_i,
    output logic             fall_o,
    output logic             low_o,
    output logic [WID_W-1:0] run_o
);

    localparam logic [WID_W-1:0] RUN_MAX = '1;

    logic smp_q;
    logic prv_q;
    logic [WID_W-1:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            smp_q <= 1'b1;
            prv_q <= 1'b1;
        end else begin
            smp_q <= chan_i;
            prv_q <= smp_q;
        end
    end

    assign fall_o = prv_q & ~smp_q;
    assign low_o  = ~smp_q;

    // run length of the latest low stretch; holds after the channel recovers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (fall_o) begin
            run_q <= WID_W'(1);
        end else if (!smp_q && run_q != RUN_MAX) begin
            run_q <= run_q + WID_W'(1);
        end
    end

    assign run_o = run_q;

endmodule

// File: rtl/gl_ctrl.sv
module gl_ctrl
    import gl_pkg::*;
#(
    parameter int unsigned CH_N    = 3,
    parameter int unsigned WIN_CYC = 4,
    parameter int unsigned WID_W   = 12,
    localparam int unsigned WC_W   = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [CH_N-1:0]       fall_i,
    input  logic [CH_N-1:0]       low_i,
    input  logic [CH_N*WID_W-1:0] run_i,
    output logic                  evt_valid_o,
    output logic [CH_N-1:0]       evt_index_o,
    output logic [WID_W-1:0]      evt_width_o,
    output logic                  evt_err_o
);

    gl_state_e        state_q, state_d;
    logic [CH_N-1:0]  hit_q;
    logic [WC_W-1:0]  win_q;
    logic             any_fall, all_high, win_done, emit;
    logic [WID_W-1:0] longest;

    assign any_fall = |fall_i;
    assign all_high = ~|low_i;
    assign win_done = (win_q == WC_W'(WIN_CYC - 1));
    assign emit     = (state_q == ST_MEASURE) && all_high;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (any_fall) state_d = ST_GATHER;
            ST_GATHER:  if (win_done) state_d = ST_MEASURE;
            ST_MEASURE: if (all_high) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        longest = '0;
        for (int k = 0; k < CH_N; k++) begin
            if (hit_q[k] && run_i[k*WID_W +: WID_W] > longest) begin
                longest = run_i[k*WID_W +: WID_W];
            end
        end
    end

    // state register with the channel set and window counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            hit_q   <= '0;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    win_q <= '0;
                    if (any_fall) hit_q <= fall_i;
                end
                ST_GATHER: begin
                    hit_q <= hit_q | fall_i;
                    if (!win_done) win_q <= win_q + WC_W'(1);
                end
                default: ;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            evt_valid_o <= 1'b0;
            evt_index_o <= '0;
            evt_width_o <= '0;
            evt_err_o   <= 1'b0;
        end else begin
            evt_valid_o <= emit;
            if (emit) begin
                evt_index_o <= hit_q;
                evt_width_o <= longest;
                evt_err_o   <= ~|hit_q;
            end
        end
    end

endmodule

// File: rtl/glitch_locator.sv
module glitch_locator #(
    parameter int unsigned CH_N    = 3,
    parameter int unsigned WIN_CYC = 4,
    parameter int unsigned WID_W   = 12,
    localparam int unsigned LINES  = (1 << CH_N) - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LINES-1:0]  lines_i,
    output logic              evt_valid_o,
    output logic [CH_N-1:0]   evt_index_o,
    output logic [WID_W-1:0]  evt_width_o,
    output logic              evt_err_o
);

    logic [CH_N-1:0]       chan, fall, low;
    logic [CH_N*WID_W-1:0] run;

    gl_fanin #(.CH_N(CH_N)) u_fanin (
        .lines_i (lines_i),
        .chan_o  (chan)
    );

    for (genvar k = 0; k < CH_N; k++) begin : g_det
        gl_chan_det #(.WID_W(WID_W)) u_det (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .chan_i (chan[k]),
            .fall_o (fall[k]),
            .low_o  (low[k]),
            .run_o  (run[k*WID_W +: WID_W])
        );
    end

    gl_ctrl #(.CH_N(CH_N), .WIN_CYC(WIN_CYC), .WID_W(WID_W)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fall_i      (fall),
        .low_i       (low),
        .run_i       (run),
        .evt_valid_o (evt_valid_o),
        .evt_index_o (evt_index_o),
        .evt_width_o (evt_width_o),
        .evt_err_o   (evt_err_o)
    );

endmodule

// File: rtl/gl_checker.sv
module gl_checker #(
    parameter int unsigned CH_N   = 3,
    parameter int unsigned WID_W  = 12,
    localparam int unsigned LINES = (1 << CH_N) - 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [LINES-1:0] lines_i,
    input logic             evt_valid_o,
    input logic [CH_N-1:0]  evt_index_o,
    input logic [WID_W-1:0] evt_width_o,
    input logic             evt_err_o
);

    // R10: strobe lasts one cycle
    a_r10_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_valid_o |=> !evt_valid_o);

    // R9: a reported event has a nonzero index and no error
    a_r9_index_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_valid_o |-> (evt_index_o != '0) && !evt_err_o);

    // R3: a reported event has a nonzero width
    a_r3_width_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_valid_o |-> evt_width_o != '0);

    // R7: the report follows an edge at which every line was sampled high
    a_r7_lines_recovered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_valid_o |-> $past(&lines_i, 2));

endmodule

bind glitch_locator gl_checker #(.CH_N(CH_N), .WID_W(WID_W)) u_gl_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lines_i     (lines_i),
    .evt_valid_o (evt_valid_o),
    .evt_index_o (evt_index_o),
    .evt_width_o (evt_width_o),
    .evt_err_o   (evt_err_o)
);

// File: tb/glitch_locator_tb_top.sv
module glitch_locator_tb_top;

    localparam int CH_N  = 3;
    localparam int WIN   = 4;
    localparam int WID_W = 6;
    localparam int LINES = (1 << CH_N) - 1;
    localparam int WMAX  = (1 << WID_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LINES-1:0] lines = '1;
    logic evt_valid, evt_err;
    logic [CH_N-1:0] evt_index;
    logic [WID_W-1:0] evt_width;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int pj[4];
    int ps[4];
    int pl[4];
    int np;

    always #5 clk = ~clk;

    glitch_locator #(.CH_N(CH_N), .WIN_CYC(WIN), .WID_W(WID_W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .lines_i     (lines),
        .evt_valid_o (evt_valid),
        .evt_index_o (evt_index),
        .evt_width_o (evt_width),
        .evt_err_o   (evt_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural model: channel low runs per edge, then merge, width, report edge
    task automatic run_case(input string tag);
        int cf[CH_N];
        int cl[CH_N];
        int first, last, mask, wid, e;
        for (int k = 0; k < CH_N; k++) begin
            cf[k] = -1;
            cl[k] = -1;
        end
        for (int t = 0; t < 400; t++) begin
            for (int k = 0; k < CH_N; k++) begin
                bit lo = 0;
                for (int i = 0; i < np; i++)
                    if (((pj[i] >> k) & 1) == 1 && t >= ps[i] && t < ps[i] + pl[i]) lo = 1;
                if (lo) begin
                    if (cf[k] < 0) cf[k] = t;
                    cl[k] = t;
                end
            end
        end
        first = 1000;
        last = -1;
        for (int k = 0; k < CH_N; k++) begin
            if (cf[k] >= 0 && cf[k] < first) first = cf[k];
            if (cl[k] > last) last = cl[k];
        end
        mask = 0;
        wid = 0;
        for (int k = 0; k < CH_N; k++) begin
            if (cf[k] >= 0 && cf[k] - first <= WIN) begin
                mask |= (1 << k);
                if (cl[k] - cf[k] + 1 > wid) wid = cl[k] - cf[k] + 1;
            end
        end
        if (wid > WMAX) wid = WMAX;
        e = (first + WIN + 2 > last + 2) ? first + WIN + 2 : last + 2;
        for (int t = 0; t <= e + 4; t++) begin
            @(negedge clk);
            chk({tag, " R7 R8 R10 strobe"}, int'(evt_valid), (t == e + 1) ? 1 : 0);
            if (t == e + 1) begin
                chk({tag, " R1 R3 R4 index"}, int'(evt_index), mask);
                chk({tag, " R5 R6 width"}, int'(evt_width), wid);
                chk({tag, " R9 error"}, int'(evt_err), 0);
            end
            if (t == e + 3) begin
                chk({tag, " R10 hold index"}, int'(evt_index), mask);
            end
            for (int j = 1; j <= LINES; j++) begin
                bit lo = 0;
                for (int i = 0; i < np; i++)
                    if (pj[i] == j && t >= ps[i] && t < ps[i] + pl[i]) lo = 1;
                lines[j-1] = !lo;
            end
        end
    endtask

    task automatic one(input int j, input int s, input int l);
        pj[np] = j;
        ps[np] = s;
        pl[np] = l;
        np++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 valid in reset", int'(evt_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 valid", int'(evt_valid), 0);
        chk("R2 index", int'(evt_index), 0);
        chk("R2 width", int'(evt_width), 0);
        chk("R2 error", int'(evt_err), 0);

        // R1 R3 R7: each line alone, short and long runs
        for (int j = 1; j <= LINES; j++) begin
            np = 0;
            one(j, 0, 2 + j);
            run_case("single");
        end
        // R4 R5: lag 3, later pulse longer
        np = 0; one(1, 0, 5); one(6, 3, 9); run_case("merge_lag3");
        // R4 boundary: lag equal to window is merged
        np = 0; one(2, 0, 6); one(4, WIN, 3); run_case("merge_edge");
        // R4 R8: lag one beyond window is dropped
        np = 0; one(4, 0, 12); one(3, WIN + 1, 3); run_case("drop_edge");
        // R5 R8: late longer pulse excluded from width and index
        np = 0; one(5, 0, 20); one(2, 8, 30); run_case("drop_long");
        // R6: saturation
        np = 0; one(7, 0, 80); run_case("saturate");
        // R5: same start, different lengths
        np = 0; one(1, 0, 4); one(2, 0, 7); run_case("same_start");

        repeat (5) @(negedge clk);
        chk("R8 quiet after events", int'(evt_valid), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule